// File: doc/BRIEF.md
# Vblank Evasion Update Guard

This block decides when a batch of double-buffered display register writes may begin. It watches a pipe's live scanline and frame counter. It holds a start request back while the scanline sits in a short guard band just before vertical blanking begins, because an update started there could be split across two frames. The guard band is a fixed time, `GUARD_US` microseconds. It is converted to scanlines from the mode timing by a small sequential divider. The divider restarts whenever the mode inputs change.

Software or a sequencer pulses `start_i` and then waits for `grant_o`. If the wait runs past `TIMEOUT_CYC` cycles, the block grants anyway and raises `late_o` to mark a possibly non-atomic update. When the writes are finished, `end_i` closes the update. The block compares the frame count captured at grant with the current frame count. If they differ, it reports a failure. For debug it also reports the start scanline, the end scanline and the elapsed cycles.

Top module: `vblank_update_guard`

## Requirements
- R1: The guard length in lines is ceil(GUARD_US × pclk_khz / (1000 × htotal)). It is produced by a sequential divider that reloads on any edge where htotal, pixel clock, vblank start or interlace differs from its value at the previous edge. The mode register clears to zero at reset. No grant is issued on the reload edge or on the next NUM_W edges, where NUM_W = max(PCLK_W + clog2(GUARD_US+1), HT_W+10) + 1.
- R2: When htotal is zero, the guard length is zero lines.
- R3: When interlace_i is 1, the effective vblank start is ceil(vbl_start_i / 2). It replaces vbl_start_i in every later use.
- R4: The guard window spans scanlines from (vblank start − guard) to (vblank start − 1), both inclusive. In the waiting state, every edge grants when the scanline at that edge is outside the window and R1 allows it. grant_o is then high for exactly the following cycle. The first decision is taken on the edge after the one that accepts start_i.
- R5: If either window bound is zero or negative, the request is granted without regard to the scanline.
- R6: The TIMEOUT_CYC-th waiting edge after the accepting edge grants regardless of the scanline or the divider, provided no grant came earlier. On that grant, late_o is high together with grant_o.
- R7: At the grant edge, the block latches the frame count, and start_line_o takes the scanline present at that edge.
- R8: The first end_i after a grant ends the update, and done_o pulses for one cycle. On the same edge, end_line_o takes the scanline and elapsed_o takes the number of edges strictly between the grant edge and this edge. fail_o pulses with done_o only when the latched frame count is nonzero and differs from frame_i at this edge.
- R9: start_i is ignored unless the block is idle, and end_i is ignored unless an update is granted and open.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| htotal_i | input | HT_W | Total pixels per line |
| pclk_khz_i | input | PCLK_W | Pixel clock in kHz |
| vbl_start_i | input | LINE_W | First line of vertical blanking |
| interlace_i | input | 1 | Interlaced mode |
| scanline_i | input | LINE_W | Live scanline |
| frame_i | input | FRAME_W | Live frame counter |
| start_i | input | 1 | Request to begin an update |
| end_i | input | 1 | Update finished |
| grant_o | output | 1 | One-cycle grant pulse |
| late_o | output | 1 | Grant came from the timeout |
| done_o | output | 1 | One-cycle update-closed pulse |
| fail_o | output | 1 | Frame boundary crossed during update |
| start_line_o | output | LINE_W | Scanline at grant |
| end_line_o | output | LINE_W | Scanline at end |
| elapsed_o | output | EL_W | Edges between grant and end |

## Verification
The bench builds the block with GUARD_US set to 10 and TIMEOUT_CYC set to 60, and keeps the default widths. With these values, a guard of four or five lines comes from small pixel clocks and line lengths, the rounding-up case (3.75 lines) is easy to produce, and the timeout falls within a short run. The divider then needs 25 steps, so a start issued just after a mode change is visibly delayed. Bypass by a nonpositive bound, the empty window when htotal is zero, and an interlaced vblank start with odd rounding can each be reached with line numbers below 50.

// File: rtl/vbe_pkg.sv
package vbe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACTIVE = 2'd2
  } vbe_state_e;
endpackage

// File: rtl/vbe_guard_div.sv
module vbe_guard_div #(
  parameter int HT_W     = 14,
  parameter int PCLK_W   = 20,
  parameter int GUARD_US = 100,
  parameter int GL_W     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic [HT_W-1:0]   htotal_i,
  input  logic [PCLK_W-1:0] pclk_khz_i,
  output logic [GL_W-1:0]   guard_o,
  output logic              ready_o
);
  localparam int GU_W  = $clog2(GUARD_US + 1);
  localparam int DEN_W = HT_W + 10;
  localparam int NUM_W = ((PCLK_W + GU_W > DEN_W) ? PCLK_W + GU_W : DEN_W) + 1;
  localparam int CNT_W = $clog2(NUM_W + 1);

  // numerator of the rounded-up quotient
  function automatic logic [NUM_W-1:0] ceil_num(input logic [HT_W-1:0] ht,
                                                input logic [PCLK_W-1:0] pk);
    logic [NUM_W-1:0] a, b;
    a = NUM_W'(GUARD_US) * NUM_W'(pk);
    b = NUM_W'(ht) * NUM_W'(1000);
    return (ht == '0) ? '0 : a + b - NUM_W'(1);
  endfunction

  function automatic logic [GL_W-1:0] sat_lines(input logic [NUM_W-1:0] q);
    return (q > NUM_W'({GL_W{1'b1}})) ? {GL_W{1'b1}} : q[GL_W-1:0];
  endfunction

  logic [DEN_W-1:0] den_q, rem_q, rem_n;
  logic [NUM_W-1:0] quo_q, quo_n;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DEN_W:0]   trial;
  logic             take;

  always_comb begin
    trial = {rem_q, quo_q[NUM_W-1]};
    take  = trial >= {1'b0, den_q};
    rem_n = take ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
    quo_n = {quo_q[NUM_W-2:0], take};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      guard_o <= '0;
    end else if (restart_i) begin
      den_q  <= DEN_W'(htotal_i) * DEN_W'(1000);
      quo_q  <= ceil_num(htotal_i, pclk_khz_i);
      rem_q  <= '0;
      cnt_q  <= CNT_W'(NUM_W);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_q  <= 1'b0;
        guard_o <= (den_q == '0) ? '0 : sat_lines(quo_n);
      end
    end
  end

  assign ready_o = !busy_q && !restart_i;

  a_r1_busy_after_reload: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !ready_o);
  a_r2_zero_line_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == CNT_W'(1) && den_q == '0) |=> guard_o == '0);
endmodule

// File: rtl/vbe_window.sv
module vbe_window #(
  parameter int LINE_W = 13,
  parameter int GL_W   = 14
) (
  input  logic [LINE_W-1:0] vbl_start_i,
  input  logic              interlace_i,
  input  logic [GL_W-1:0]   guard_i,
  input  logic [LINE_W-1:0] scanline_i,
  output logic              bypass_o,
  output logic              in_win_o
);
  localparam int SW = LINE_W + 2;

  function automatic logic [LINE_W-1:0] eff_start(input logic [LINE_W-1:0] v,
                                                  input logic il);
    logic [LINE_W:0] up;
    up = {1'b0, v} + (LINE_W+1)'(1);
    return il ? up[LINE_W:1] : v;
  endfunction

  logic [LINE_W-1:0] ve;
  logic signed [SW-1:0] lo, hi, sl;

  always_comb begin
    ve       = eff_start(vbl_start_i, interlace_i);
    lo       = $signed({2'b00, ve}) - $signed({1'b0, guard_i});
    hi       = $signed({2'b00, ve}) - $signed(SW'(1));
    sl       = $signed({2'b00, scanline_i});
    bypass_o = (lo <= 0) || (hi <= 0);
    in_win_o = (sl >= lo) && (sl <= hi);
  end
endmodule

// File: rtl/vblank_update_guard.sv
module vblank_update_guard #(
  parameter int HT_W        = 14,
  parameter int PCLK_W      = 20,
  parameter int LINE_W      = 13,
  parameter int FRAME_W     = 32,
  parameter int EL_W        = 24,
  parameter int GUARD_US    = 100,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HT_W-1:0]    htotal_i,
  input  logic [PCLK_W-1:0]  pclk_khz_i,
  input  logic [LINE_W-1:0]  vbl_start_i,
  input  logic               interlace_i,
  input  logic [LINE_W-1:0]  scanline_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               start_i,
  input  logic               end_i,
  output logic               grant_o,
  output logic               late_o,
  output logic               done_o,
  output logic               fail_o,
  output logic [LINE_W-1:0]  start_line_o,
  output logic [LINE_W-1:0]  end_line_o,
  output logic [EL_W-1:0]    elapsed_o
);
  import vbe_pkg::*;

  localparam int GL_W   = LINE_W + 1;
  localparam int TM_W   = $clog2(TIMEOUT_CYC + 1);
  localparam int MODE_W = HT_W + PCLK_W + LINE_W + 1;

  logic [MODE_W-1:0]  mode_now, mode_q;
  logic               mode_chg, div_ready, bypass, in_win;
  logic [GL_W-1:0]    guard;
  vbe_state_e         st;
  logic [TM_W-1:0]    timer;
  logic [EL_W-1:0]    el_q;
  logic [FRAME_W-1:0] start_fc;
  logic               line_ok, tmo_hit;

  assign mode_now = {htotal_i, pclk_khz_i, vbl_start_i, interlace_i};
  assign mode_chg = mode_now != mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_now;
  end

  vbe_guard_div #(.HT_W(HT_W), .PCLK_W(PCLK_W), .GUARD_US(GUARD_US), .GL_W(GL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart_i(mode_chg), .htotal_i(htotal_i),
    .pclk_khz_i(pclk_khz_i), .guard_o(guard), .ready_o(div_ready));

  vbe_window #(.LINE_W(LINE_W), .GL_W(GL_W)) u_win (
    .vbl_start_i(vbl_start_i), .interlace_i(interlace_i), .guard_i(guard),
    .scanline_i(scanline_i), .bypass_o(bypass), .in_win_o(in_win));

  assign line_ok = div_ready && (bypass || !in_win);
  assign tmo_hit = timer == TM_W'(TIMEOUT_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      timer        <= '0;
      el_q         <= '0;
      start_fc     <= '0;
      grant_o      <= 1'b0;
      late_o       <= 1'b0;
      done_o       <= 1'b0;
      fail_o       <= 1'b0;
      start_line_o <= '0;
      end_line_o   <= '0;
      elapsed_o    <= '0;
    end else begin
      grant_o <= 1'b0;
      late_o  <= 1'b0;
      done_o  <= 1'b0;
      fail_o  <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          st    <= ST_WAIT;
          timer <= '0;
        end
        ST_WAIT: if (line_ok || tmo_hit) begin
          st           <= ST_ACTIVE;
          grant_o      <= 1'b1;
          late_o       <= !line_ok;
          start_fc     <= frame_i;
          start_line_o <= scanline_i;
          el_q         <= '0;
        end else begin
          timer <= timer + TM_W'(1);
        end
        ST_ACTIVE: if (end_i) begin
          st         <= ST_IDLE;
          done_o     <= 1'b1;
          fail_o     <= (start_fc != '0) && (frame_i != start_fc);
          end_line_o <= scanline_i;
          elapsed_o  <= el_q;
        end else if (el_q != '1) begin
          el_q <= el_q + EL_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r4_hold_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && div_ready && !bypass && in_win && !tmo_hit) |=> !grant_o);
  a_r1_no_grant_while_dividing: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !div_ready && !tmo_hit) |=> !grant_o);
  a_r6_late_rides_grant: assert property (@(posedge clk) disable iff (!rst_n)
    late_o |-> grant_o);
  a_r8_fail_rides_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> done_o);
  a_r9_done_only_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(st == ST_ACTIVE));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_o, done_o}));
endmodule

// File: tb/vblank_update_guard_bench.sv
module vblank_update_guard_bench;
  localparam int HT_W = 14, PCLK_W = 20, LINE_W = 13, FRAME_W = 32, EL_W = 24;
  localparam int GUARD = 10, TMO = 60;
  localparam int GU_W = $clog2(GUARD + 1);
  localparam int NUMW = ((PCLK_W + GU_W > HT_W + 10) ? PCLK_W + GU_W : HT_W + 10) + 1;

  logic clk = 0, rst_n = 0;
  logic [HT_W-1:0] htotal = 0;
  logic [PCLK_W-1:0] pclk = 0;
  logic [LINE_W-1:0] vbl = 0, sl = 0;
  logic il = 0, start = 0, endr = 0;
  logic [FRAME_W-1:0] frame = 0;
  logic grant, late, done, fail;
  logic [LINE_W-1:0] sline, eline;
  logic [EL_W-1:0] elapsed;

  int checks = 0, fails = 0;
  bit running = 0;

  always #5 clk = ~clk;

  vblank_update_guard #(.HT_W(HT_W), .PCLK_W(PCLK_W), .LINE_W(LINE_W), .FRAME_W(FRAME_W),
    .EL_W(EL_W), .GUARD_US(GUARD), .TIMEOUT_CYC(TMO)) u_vblank_update_guard (
    .clk(clk), .rst_n(rst_n), .htotal_i(htotal), .pclk_khz_i(pclk), .vbl_start_i(vbl),
    .interlace_i(il), .scanline_i(sl), .frame_i(frame), .start_i(start), .end_i(endr),
    .grant_o(grant), .late_o(late), .done_o(done), .fail_o(fail),
    .start_line_o(sline), .end_line_o(eline), .elapsed_o(elapsed));

  task automatic chk(input bit ok, input string req, input string what, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model, behavioural
  function automatic int guard_lines(int ht, int pk);
    if (ht == 0) return 0;
    return (GUARD * pk + 1000 * ht - 1) / (1000 * ht);
  endfunction

  int m_st = 0, m_t = 0, m_el = 0, m_steps = NUMW;
  longint m_sfc = 0;
  int p_ht = 0, p_pk = 0, p_vb = 0, p_il = 0;
  bit e_grant = 0, e_late = 0, e_done = 0, e_fail = 0;
  int e_sline = 0, e_eline = 0, e_el = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_el = 0; m_steps = NUMW; m_sfc = 0;
      p_ht = 0; p_pk = 0; p_vb = 0; p_il = 0;
      e_grant = 0; e_late = 0; e_done = 0; e_fail = 0;
      e_sline = 0; e_eline = 0; e_el = 0;
    end else begin
      bit chg, rdy, ok;
      int ve, g, lo, hi;
      chg = (int'(htotal) != p_ht) || (int'(pclk) != p_pk) || (int'(vbl) != p_vb) || (int'(il) != p_il);
      rdy = !chg && (m_steps == NUMW);
      if (chg) m_steps = 0; else if (m_steps < NUMW) m_steps++;
      p_ht = int'(htotal); p_pk = int'(pclk); p_vb = int'(vbl); p_il = int'(il);
      e_grant = 0; e_late = 0; e_done = 0; e_fail = 0;
      ve = il ? (int'(vbl) + 1) / 2 : int'(vbl);
      g  = guard_lines(int'(htotal), int'(pclk));
      lo = ve - g; hi = ve - 1;
      ok = rdy && (lo <= 0 || hi <= 0 || int'(sl) < lo || int'(sl) > hi);
      case (m_st)
        0: if (start) begin m_st = 1; m_t = 0; end
        1: if (ok || m_t == TMO - 1) begin
             e_grant = 1; e_late = !ok; m_sfc = frame; e_sline = int'(sl); m_el = 0; m_st = 2;
           end else m_t++;
        default: if (endr) begin
             e_done = 1; e_fail = (m_sfc != 0) && (longint'(frame) != m_sfc);
             e_eline = int'(sl); e_el = m_el; m_st = 0;
           end else m_el++;
      endcase
    end
  end

  always @(negedge clk) if (running) begin
    chk(grant == e_grant, "R4", "model grant", grant, e_grant);
    chk(late == e_late, "R6", "model late", late, e_late);
    chk(done == e_done && fail == e_fail, "R8", "model done/fail", {done, fail}, {e_done, e_fail});
    chk(int'(sline) == e_sline, "R7", "model start line", sline, e_sline);
    chk(int'(eline) == e_eline && int'(elapsed) == e_el, "R8", "model end line/elapsed",
        {eline, elapsed}, {e_eline[LINE_W-1:0], e_el[EL_W-1:0]});
  end

  task automatic set_mode(input int ht, input int pk, input int vb, input bit i);
    @(negedge clk);
    htotal = HT_W'(ht); pclk = PCLK_W'(pk); vbl = LINE_W'(vb); il = i;
    repeat (NUMW + 3) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic pulse_end();
    @(negedge clk); endr = 1;
    @(negedge clk); endr = 0;
  endtask

  task automatic wait_grant(input int maxc, output int n);
    n = 0;
    while (n < maxc) begin
      @(negedge clk); n++;
      if (grant) return;
    end
    n = -1;
  endtask

  int n;

  initial begin
    repeat (3) @(negedge clk);
    chk(!grant && !late && !done && !fail && sline == 0 && eline == 0 && elapsed == 0,
        "R10", "reset outputs", {grant, late, done, fail}, 0);
    rst_n = 1;
    running = 1;

    // guard ceil(15000/4000)=4, window 16..19
    set_mode(4, 1500, 20, 0);
    sl = 10; frame = 5;
    pulse_start();
    wait_grant(5, n);
    chk(n == 1, "R4", "grant outside window latency", n, 1);
    chk(sline == 10 && !late, "R7", "start line latched", sline, 10);
    repeat (3) @(negedge clk);
    sl = 12;
    pulse_end();
    chk(done && !fail, "R8", "same frame no failure", {done, fail}, 2);
    chk(eline == 12 && elapsed == 4, "R8", "elapsed edges", elapsed, 4);

    // stall at 16 (lower bound, rounded-up guard), release at 20
    sl = 16;
    pulse_start();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!grant, "R1", "ceil guard holds line 16", grant, 0);
    end
    sl = 20;
    wait_grant(3, n);
    chk(n == 1 && sline == 20, "R4", "grant after leaving window", sline, 20);
    frame = 6;
    pulse_end();
    chk(fail, "R8", "frame crossed flags failure", fail, 1);

    // latched frame of zero never flags
    frame = 0; sl = 5;
    pulse_start();
    wait_grant(5, n);
    frame = 1;
    pulse_end();
    chk(done && !fail, "R8", "zero start frame no failure", fail, 0);

    // stuck at 19: timeout
    sl = 19;
    pulse_start();
    wait_grant(TMO + 5, n);
    chk(n == TMO && late, "R6", "timeout grant latency", n, TMO);
    // start while open ignored
    pulse_start();
    pulse_end();
    repeat (8) @(negedge clk);
    chk(!grant, "R9", "start while open ignored", grant, 0);
    pulse_end();
    chk(!done, "R9", "end while idle ignored", done, 0);

    // start right after a mode change: divider delays the grant
    sl = 2;
    @(negedge clk); htotal = 2; pclk = 1000;
    start = 1; @(negedge clk); start = 0;
    wait_grant(TMO + 5, n);
    chk(n == NUMW + 1 && !late, "R1", "divider delays grant", n, NUMW + 1);
    pulse_end();

    // htotal zero: empty window, line 19 grants
    set_mode(0, 1500, 20, 0);
    sl = 19;
    pulse_start();
    wait_grant(5, n);
    chk(n == 1 && !late, "R2", "zero htotal no guard", n, 1);
    pulse_end();

    // interlace: ceil(41/2)=21, window 17..20
    set_mode(4, 1500, 41, 1);
    sl = 20;
    pulse_start();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!grant, "R3", "interlaced window holds line 20", grant, 0);
    end
    sl = 21;
    wait_grant(3, n);
    chk(n == 1 && sline == 21, "R3", "interlaced release at 21", sline, 21);
    pulse_end();

    // bypass: lower bound 3-4 negative
    set_mode(4, 1500, 3, 0);
    sl = 1;
    pulse_start();
    wait_grant(5, n);
    chk(n == 1 && !late, "R5", "nonpositive bound bypass", n, 1);
    pulse_end();

    repeat (4) @(negedge clk);
    running = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule